// File: doc/BRIEF.md
# Gated Timer Channel with Dual Edge Capture

A single timer channel whose counter steps on rising edges of a primary count source. Its mode selects holding, free counting, or gated counting. In gated counting, steps are taken only while an external secondary input is high. The block can therefore measure how many primary edges fall inside each high phase of the secondary signal.

The secondary input is asynchronous. It is brought into the clock domain through a two-flop synchroniser, and its edges feed two independent capture units. Each unit copies the counter into its own capture register on the edges its mode selects, then sets a sticky flag. Enabled flags drive one interrupt line.

Capture only happens while the channel is armed. In continuous operation the arm state stays set and every matching edge overwrites the capture register. In one-shot operation each enabled unit captures once. The arm state then drops by itself when all enabled units have captured.

Top module: `gated_capture_timer`

## Requirements
- R1: While rst_ni is low, cnt_o, cpt1_o, cpt2_o, flag_o, armed_o and irq_o are all zero.
- R2: With cnt_mode_i = 01 (free), the counter takes one step at each clock edge where pri_i is sampled high after having been sampled low at the previous edge.
- R3: With cnt_mode_i = 10 (gated), a primary rising edge steps the counter only if the synchronised secondary level is high. sec_i reaches that level after two clock edges.
- R4: With cnt_mode_i = 00 or 11 (hold), cnt_o does not change.
- R5: dir_i = 0 makes a step add one and dir_i = 1 makes it subtract one, wrapping modulo 2^CNT_W.
- R6: Capture mode encoding per unit: 00 off, 01 falling edge, 10 rising edge, 11 both. On a matching synchronised edge, the unit loads cnt_o as it was before that clock edge.
- R7: While armed_o is 0 no capture register or flag is set by an edge. arm_clr_i clears armed_o at the next edge and overrides arm_set_i. arm_set_i sets armed_o.
- R8: With oneshot_i = 1, each enabled unit captures at most once per arming. armed_o clears itself once every unit with a non-zero mode has captured. arm_set_i restarts the one-shot and wins over the self-clear.
- R9: With oneshot_i = 0, armed_o stays set, and every matching edge overwrites the capture register and sets the flag again.
- R10: flag_o bits are sticky. Bit k clears when flag_clr_i[k] is 1, unless a capture of unit k happens in the same cycle, in which case the flag stays set.
- R11: irq_o is high exactly when some flag_o[k] and irq_en_i[k] are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_i | input | 1 | Primary count source, synchronous to clk_i |
| sec_i | input | 1 | Asynchronous secondary input: gate and capture trigger |
| cnt_mode_i | input | 2 | 00 hold, 01 free, 10 gated, 11 hold |
| dir_i | input | 1 | 0 count up, 1 count down |
| cpt1_mode_i | input | 2 | Edge select of capture unit 1 |
| cpt2_mode_i | input | 2 | Edge select of capture unit 2 |
| oneshot_i | input | 1 | 1 one-shot, 0 continuous capture |
| arm_set_i | input | 1 | Pulse: arm capture |
| arm_clr_i | input | 1 | Pulse: disarm capture |
| irq_en_i | input | 2 | Interrupt enable per capture flag |
| flag_clr_i | input | 2 | Write-one-to-clear per capture flag |
| cnt_o | output | CNT_W | Counter value |
| cpt1_o | output | CNT_W | Capture register of unit 1 |
| cpt2_o | output | CNT_W | Capture register of unit 2 |
| flag_o | output | 2 | Sticky capture flags |
| armed_o | output | 1 | Capture arm state |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences come first.
- A steady primary toggle in free mode pins the step rule.
- The same toggle with the secondary held low separates gated mode from free mode.
- Hold mode and down counting through zero expose stepping and direction errors.
- A gated high pulse followed by a falling edge, with only unit 2 set to falling capture, shows that the captured value is the count accumulated during the pulse. It also shows that unit 1 stays idle.

Random phases then vary the primary activity, the secondary pulse widths, both capture modes, arm and disarm pulses, flag clears and one-shot versus continuous operation. This separates the self-clear rule, the priority of clear over set and the per-unit done tracking. Each cycle is compared against a bench model built from the requirements.

// File: rtl/gcap_pkg.sv
package gcap_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'b00,
    CNT_FREE  = 2'b01,
    CNT_GATED = 2'b10,
    CNT_HOLDX = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    CPT_OFF  = 2'b00,
    CPT_FALL = 2'b01,
    CPT_RISE = 2'b10,
    CPT_BOTH = 2'b11
  } cpt_mode_e;
endpackage

// File: rtl/gcap_sync.sv
module gcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = lvl_o & ~last_q;
  assign fall_o = ~lvl_o & last_q;
endmodule

// File: rtl/gcap_counter.sv
module gcap_counter
  import gcap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             pri_rise_i,
  input  logic             gate_i,
  input  logic             dir_i,
  output logic [CNT_W-1:0] cnt_o
);
  cnt_mode_e mode;
  logic      step;

  assign mode = cnt_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      CNT_FREE:  step = pri_rise_i;
      CNT_GATED: step = pri_rise_i & gate_i;
      default:   step = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (step) cnt_o <= dir_i ? cnt_o - 1'b1 : cnt_o + 1'b1;
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) |=> $stable(cnt_o));

  // R3
  gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !gate_i) |=> $stable(cnt_o));
endmodule

// File: rtl/gcap_unit.sv
module gcap_unit
  import gcap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             armed_i,
  input  logic             oneshot_i,
  input  logic             rearm_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cpt_o,
  output logic             flag_o,
  output logic             hit_o,
  output logic             done_o
);
  logic edge_sel;

  always_comb begin
    unique case (cpt_mode_e'(mode_i))
      CPT_FALL: edge_sel = fall_i;
      CPT_RISE: edge_sel = rise_i;
      CPT_BOTH: edge_sel = rise_i | fall_i;
      default:  edge_sel = 1'b0;
    endcase
  end

  // one-shot: a unit that already fired stays quiet until re-armed
  assign hit_o = armed_i & edge_sel & ~(oneshot_i & done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpt_o  <= '0;
      flag_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (hit_o) cpt_o <= cnt_i;
      if (hit_o)           flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
      if (rearm_i)    done_o <= 1'b0;
      else if (hit_o) done_o <= 1'b1;
    end
  end

  // R7
  no_cpt_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(cpt_o));

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R7
  flag_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/gated_capture_timer.sv
module gated_capture_timer
  import gcap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pri_i,
  input  logic             sec_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic             dir_i,
  input  logic [1:0]       cpt1_mode_i,
  input  logic [1:0]       cpt2_mode_i,
  input  logic             oneshot_i,
  input  logic             arm_set_i,
  input  logic             arm_clr_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cpt1_o,
  output logic [CNT_W-1:0] cpt2_o,
  output logic [1:0]       flag_o,
  output logic             armed_o,
  output logic             irq_o
);
  localparam int unsigned NUM_CPT = 2;

  logic sec_lvl, sec_rise, sec_fall;
  logic pri_q, pri_rise;

  logic [NUM_CPT-1:0][1:0]       mode_a;
  logic [NUM_CPT-1:0][CNT_W-1:0] cpt_a;
  logic [NUM_CPT-1:0]            hit_a, done_a, en_a;
  logic                          all_fired;

  gcap_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sec_i),
    .lvl_o  (sec_lvl),
    .rise_o (sec_rise),
    .fall_o (sec_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pri_q <= 1'b0;
    else         pri_q <= pri_i;
  end
  assign pri_rise = pri_i & ~pri_q;

  gcap_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cnt_mode_i),
    .pri_rise_i (pri_rise),
    .gate_i     (sec_lvl),
    .dir_i      (dir_i),
    .cnt_o      (cnt_o)
  );

  assign mode_a = {cpt2_mode_i, cpt1_mode_i};

  for (genvar k = 0; k < NUM_CPT; k++) begin : g_cpt
    assign en_a[k] = |mode_a[k];
    gcap_unit #(.CNT_W(CNT_W)) i_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_a[k]),
      .armed_i    (armed_o),
      .oneshot_i  (oneshot_i),
      .rearm_i    (arm_set_i),
      .rise_i     (sec_rise),
      .fall_i     (sec_fall),
      .cnt_i      (cnt_o),
      .flag_clr_i (flag_clr_i[k]),
      .cpt_o      (cpt_a[k]),
      .flag_o     (flag_o[k]),
      .hit_o      (hit_a[k]),
      .done_o     (done_a[k])
    );
  end

  assign cpt1_o = cpt_a[0];
  assign cpt2_o = cpt_a[1];

  // every enabled unit has fired by the end of this cycle
  assign all_fired = (|en_a) & (&((done_a | hit_a) | ~en_a));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_o <= 1'b0;
    else if (arm_clr_i) armed_o <= 1'b0;
    else if (arm_set_i) armed_o <= 1'b1;
    else if (armed_o && oneshot_i && all_fired) armed_o <= 1'b0;
  end

  assign irq_o = |(flag_o & irq_en_i);

  // R9
  cont_arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !oneshot_i && !arm_clr_i) |=> armed_o);

  // R7
  arm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_clr_i |=> !armed_o);

  // R8
  self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !arm_clr_i && !arm_set_i && $fell(armed_o) == 1'b0 && !oneshot_i) |=> armed_o);

  // R11
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o != 2'b00));
endmodule

// File: tb/test_gated_capture_timer.sv
`timescale 1ns/1ps
module test_gated_capture_timer;
  localparam int W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pri_i = 0, sec_i = 0, dir_i = 0, oneshot_i = 0, arm_set_i = 0, arm_clr_i = 0;
  logic [1:0] cnt_mode_i = 0, cpt1_mode_i = 0, cpt2_mode_i = 0, irq_en_i = 0, flag_clr_i = 0;
  logic [W-1:0] cnt_o, cpt1_o, cpt2_o;
  logic [1:0] flag_o;
  logic armed_o, irq_o;

  int total = 0, bad = 0;
  bit done_run = 0;

  always #4 clk_i = ~clk_i;

  gated_capture_timer #(.CNT_W(W)) i_gated_capture_timer (.*);

  // reference model built from the requirements
  logic m_s1, m_s2, m_s3, m_p, m_arm;
  logic [W-1:0] m_cnt;
  logic [W-1:0] m_cpt [2];
  logic [1:0] m_flag, m_done;

  function automatic logic sel_edge(logic [1:0] md, logic r, logic f);
    case (md)
      2'b01: return f;
      2'b10: return r;
      2'b11: return r | f;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, logic [1:0] md, logic prise,
                                             logic gate, logic dn);
    logic step;
    step = prise && (md == 2'b01 || (md == 2'b10 && gate));
    if (!step) return c;
    return dn ? c - 1'b1 : c + 1'b1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_p = 0; m_arm = 0;
      m_cnt = '0; m_cpt[0] = '0; m_cpt[1] = '0; m_flag = '0; m_done = '0;
    end else begin
      logic r, f, prise, any_en, fired, a_next;
      logic [1:0] hit, md;
      logic [W-1:0] old_cnt;
      r = m_s2 & ~m_s3; f = ~m_s2 & m_s3;
      prise = pri_i & ~m_p;
      old_cnt = m_cnt;
      m_cnt = next_cnt(m_cnt, cnt_mode_i, prise, m_s2, dir_i);
      any_en = 0; fired = 1;
      for (int k = 0; k < 2; k++) begin
        md = (k == 0) ? cpt1_mode_i : cpt2_mode_i;
        hit[k] = m_arm && sel_edge(md, r, f) && !(oneshot_i && m_done[k]);
        if (md != 0) begin
          any_en = 1;
          if (!(m_done[k] || hit[k])) fired = 0;
        end
      end
      a_next = m_arm;
      if (arm_clr_i) a_next = 0;
      else if (arm_set_i) a_next = 1;
      else if (m_arm && oneshot_i && any_en && fired) a_next = 0;
      for (int k = 0; k < 2; k++) begin
        if (hit[k]) m_cpt[k] = old_cnt;
        if (hit[k]) m_flag[k] = 1; else if (flag_clr_i[k]) m_flag[k] = 0;
        if (arm_set_i) m_done[k] = 0; else if (hit[k]) m_done[k] = 1;
      end
      m_arm = a_next;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sec_i; m_p = pri_i;
    end
  end

  task automatic check_eq(string req, string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_model();
    check_eq("R2/R3/R4/R5 R2", "cnt", cnt_o, m_cnt);
    check_eq("R6", "cpt1", cpt1_o, m_cpt[0]);
    check_eq("R6 R9", "cpt2", cpt2_o, m_cpt[1]);
    check_eq("R10", "flag", flag_o, m_flag);
    check_eq("R7 R8", "armed", armed_o, m_arm);
    check_eq("R11", "irq", irq_o, |(m_flag & irq_en_i));
  endtask

  // one cycle: sample after the edge, then drive next inputs
  task automatic step_cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    arm_set_i = 0; arm_clr_i = 0; flag_clr_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #3;
    // R1 reset state
    check_eq("R1", "cnt", cnt_o, 0);
    check_eq("R1", "cpt1", cpt1_o, 0);
    check_eq("R1", "cpt2", cpt2_o, 0);
    check_eq("R1", "flag", flag_o, 0);
    check_eq("R1", "armed", armed_o, 0);
    check_eq("R1", "irq", irq_o, 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;

    // R2 free counting: toggle pri, 5 rising edges
    cnt_mode_i = 2'b01;
    for (int i = 0; i < 10; i++) begin pri_i = ~pri_i; step_cyc(); end
    check_eq("R2", "cnt free", cnt_o, 5);

    // R3 gated with sec low: no steps
    cnt_mode_i = 2'b10; pri_i = 0;
    for (int i = 0; i < 10; i++) begin pri_i = ~pri_i; step_cyc(); end
    check_eq("R3", "cnt gated low", cnt_o, 5);

    // R4 hold
    cnt_mode_i = 2'b11;
    for (int i = 0; i < 6; i++) begin pri_i = ~pri_i; step_cyc(); end
    check_eq("R4", "cnt hold", cnt_o, 5);

    // R6 falling capture on unit 2 after gated pulse; R11 irq
    cnt_mode_i = 2'b10; cpt2_mode_i = 2'b01; cpt1_mode_i = 2'b00; irq_en_i = 2'b10;
    pri_i = 0; arm_set_i = 1; step_cyc();
    check_eq("R7", "armed after set", armed_o, 1);
    sec_i = 1; step_cyc(); step_cyc();   // synchroniser fill, level now high
    for (int i = 0; i < 8; i++) begin pri_i = ~pri_i; step_cyc(); end
    check_eq("R3", "cnt gated high", cnt_o, 9);
    sec_i = 0; pri_i = 0;
    for (int i = 0; i < 4; i++) step_cyc();
    check_eq("R6", "cpt2 falling", cpt2_o, 9);
    check_eq("R6", "cpt1 idle", cpt1_o, 0);
    check_eq("R10", "flag2", flag_o, 2'b10);
    check_eq("R11", "irq", irq_o, 1);
    check_eq("R9", "armed stays", armed_o, 1);
    flag_clr_i = 2'b10; step_cyc();
    check_eq("R10", "flag cleared", flag_o, 0);
    check_eq("R11", "irq low", irq_o, 0);

    // R5 down through zero
    cnt_mode_i = 2'b01; dir_i = 1;
    for (int i = 0; i < 20; i++) begin pri_i = ~pri_i; step_cyc(); end
    check_eq("R5", "cnt down wrap", cnt_o, 16'hFFFF);
    dir_i = 0;
    check_model();

    // random phases against the model
    for (int ph = 0; ph < 40; ph++) begin
      cnt_mode_i  = 2'($urandom_range(0, 3));
      cpt1_mode_i = 2'($urandom_range(0, 3));
      cpt2_mode_i = 2'($urandom_range(0, 3));
      oneshot_i   = 1'($urandom_range(0, 1));
      dir_i       = ($urandom_range(0, 5) == 0);
      irq_en_i    = 2'($urandom_range(0, 3));
      for (int c = 0; c < 150; c++) begin
        pri_i = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 7) == 0) sec_i = ~sec_i;
        if ($urandom_range(0, 40) == 0) arm_set_i = 1;
        if ($urandom_range(0, 90) == 0) arm_clr_i = 1;
        if ($urandom_range(0, 20) == 0) flag_clr_i = 2'($urandom_range(1, 3));
        step_cyc();
        check_model();
      end
    end
    done_run = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done_run) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule